// File: doc/BRIEF.md
# Clock-Enable and Power-Mode Controller

This block sits beside the core of a small 8-bit microcontroller and decides, on every oscillator clock, which parts of the chip receive clock enables. It has three operating states:

- **Run:** everything is clocked.
- **Idle:** the CPU clock enable is withdrawn, while the peripheral enable stays on. The peripheral enable covers RAM, timer/counters, serial port and interrupt logic.
- **Halt (power-down):** every enable is withdrawn and all internal state is held.

Software enters these states through a one-cycle mode write that carries an idle bit and a power-down bit. Leaving the states works differently:

- An interrupt request wakes the block from idle.
- Only a qualified hardware reset leaves halt.

The external reset pin passes through a synchroniser and then a qualification counter. The internal reset is raised only after the pin has stayed high for a full window of two machine cycles. One machine cycle is twelve oscillator clocks. Any low sample restarts the window.

The block also produces the machine-cycle strobe, one pulse every twelve clocks while the peripherals are enabled. Because the logic is fully static, its phase simply holds while the clocks are gated.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While idle_o is 1, cpu_clk_en_o is 0 and periph_clk_en_o is 1.
- R2: While pdown_o is 1, cpu_clk_en_o, periph_clk_en_o and mcyc_tick_o are all 0.
- R3: Once halted, the block leaves halt only through core_rst_o. Interrupt requests and mode writes arriving during halt have no effect.
- R4: core_rst_o rises on the 26th rising clock edge counted from the first edge that samples rst_pin_i high: two synchroniser stages plus 24 consecutive high samples. It stays high while the pin stays high.
- R5: A single low sample of the synchronised pin clears the qualification count. A pulse shorter than the window, or one split by a glitch, never raises core_rst_o. core_rst_o falls on the third edge after the pin goes low.
- R6: In idle, a wake_irq_i pulse returns the block to run on the next edge. In run, wake_irq_i has no effect.
- R7: A mode write (mode_wr_i=1) in run with set_pdown_i=1 enters halt, even when set_idle_i=1 in the same write. With only set_idle_i=1 it enters idle.
- R8: While core_rst_o is 1, both mode bits are cleared (run state) and the machine-cycle phase is held at zero.
- R9: While the peripherals are enabled, mcyc_tick_o pulses for one clock every 12 clocks, including across idle. The phase does not advance during halt.
- R10: A mode write with both bits 0 has no effect, and mode writes during idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_pin_i | input | 1 | Raw external reset pin, active high, asynchronous |
| mode_wr_i | input | 1 | One-cycle strobe of a software mode write |
| set_idle_i | input | 1 | Idle bit of the mode write |
| set_pdown_i | input | 1 | Power-down bit of the mode write |
| wake_irq_i | input | 1 | Any enabled interrupt request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Enable for RAM, timers, serial port and interrupt logic |
| core_rst_o | output | 1 | Qualified synchronous internal reset |
| mcyc_tick_o | output | 1 | Machine-cycle strobe |
| idle_o | output | 1 | Idle mode bit |
| pdown_o | output | 1 | Power-down mode bit |

## Verification
The bench builds the block with its defaults: 12 clocks per machine cycle, a two-machine-cycle qualification window and two synchroniser stages. This puts the 24-sample window, its off-by-one edges and the split-pulse case within a few dozen clocks. A behavioural model counts samples, tracks the mode and the twelve-clock phase with plain integers, and is compared on every clock. Directed checks pin down the exact rising edge of the internal reset, the tick cadence over four machine cycles, and the inputs that halt must ignore.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_HALT = 2'd2
  } pm_state_e;

  // Length of the reset qualification window in oscillator clocks.
  function automatic int unsigned qual_window(int unsigned osc_per_mc,
                                              int unsigned mc_count);
    return osc_per_mc * mc_count;
  endfunction

  // Next mode given the current mode and the request inputs (reset handled apart).
  function automatic pm_state_e mode_step(pm_state_e cur, logic wr,
                                          logic idle_bit, logic pdown_bit,
                                          logic wake);
    pm_state_e nxt;
    nxt = cur;
    unique case (cur)
      PM_RUN: begin
        if (wr && pdown_bit)     nxt = PM_HALT;
        else if (wr && idle_bit) nxt = PM_IDLE;
      end
      PM_IDLE: if (wake) nxt = PM_RUN;
      PM_HALT: nxt = PM_HALT;
      default: nxt = PM_RUN;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int unsigned OSC_PER_MC  = 12,
  parameter int unsigned QUAL_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_pin_i,
  output logic core_rst_o
);
  import pmc_pkg::*;

  localparam int unsigned QLEN = qual_window(OSC_PER_MC, QUAL_MC);
  localparam int unsigned CW   = $clog2(QLEN + 1);
  localparam logic [CW-1:0] QMAX = CW'(QLEN);
  localparam logic [CW-1:0] QPRE = CW'(QLEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_hi;
  logic [CW-1:0]          qual_cnt;

  function automatic logic [CW-1:0] count_step(logic [CW-1:0] cur, logic hi);
    if (!hi)         return '0;
    else if (cur == QMAX) return cur;
    else             return cur + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin_i};
  end

  assign sync_hi = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    qual_cnt <= count_step(qual_cnt, sync_hi);
  end

  assign core_rst_o = (qual_cnt == QMAX);

  // R4: the reset only rises out of a full window of high samples.
  assert_rise_after_window_R4: assert property (@(posedge clk_i)
    disable iff (!sync_hi)
    $rose(core_rst_o) |-> ($past(qual_cnt) == QPRE))
    else $error("R4 internal reset rose early");

  // R5: a low synchronised sample restarts the window.
  assert_low_clears_R5: assert property (@(posedge clk_i)
    disable iff (core_rst_o)
    !sync_hi |=> (qual_cnt == '0))
    else $error("R5 qualification count not cleared");

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm (
  input  logic               clk_i,
  input  logic               core_rst_i,
  input  logic               mode_wr_i,
  input  logic               set_idle_i,
  input  logic               set_pdown_i,
  input  logic               wake_irq_i,
  output pmc_pkg::pm_state_e state_o
);
  import pmc_pkg::*;

  pm_state_e state_q;

  always_ff @(posedge clk_i) begin
    if (core_rst_i) state_q <= PM_RUN;
    else            state_q <= mode_step(state_q, mode_wr_i, set_idle_i,
                                         set_pdown_i, wake_irq_i);
  end

  assign state_o = state_q;

  // R6: an interrupt request wakes idle on the next edge.
  assert_wake_idle_R6: assert property (@(posedge clk_i)
    disable iff (core_rst_i)
    (state_q == PM_IDLE) && wake_irq_i |=> (state_q == PM_RUN))
    else $error("R6 idle not left on wake");

  // R7: power-down wins over idle in the same write.
  assert_halt_priority_R7: assert property (@(posedge clk_i)
    disable iff (core_rst_i)
    (state_q == PM_RUN) && mode_wr_i && set_pdown_i |=> (state_q == PM_HALT))
    else $error("R7 power-down write not taken");

  // R8: leaving reset always starts from run.
  assert_reset_clears_R8: assert property (@(posedge clk_i)
    disable iff (core_rst_i)
    $fell(core_rst_i) |-> (state_q == PM_RUN))
    else $error("R8 mode bits survive reset");

endmodule

// File: rtl/pmc_mcyc_timer.sv
module pmc_mcyc_timer #(
  parameter int unsigned OSC_PER_MC = 12
) (
  input  logic clk_i,
  input  logic core_rst_i,
  input  logic run_en_i,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(OSC_PER_MC);
  localparam logic [PW-1:0] PLAST = PW'(OSC_PER_MC - 1);

  logic [PW-1:0] phase_q;

  function automatic logic [PW-1:0] phase_step(logic [PW-1:0] cur);
    return (cur == PLAST) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (core_rst_i)    phase_q <= '0;
    else if (run_en_i) phase_q <= phase_step(phase_q);
  end

  assign tick_o = run_en_i && (phase_q == PLAST);

  // R9: static logic, gated phase holds its value.
  assert_phase_frozen_R9: assert property (@(posedge clk_i)
    disable iff (core_rst_i)
    !run_en_i |=> $stable(phase_q))
    else $error("R9 phase moved while gated");

  // R8: reset holds phase at zero.
  assert_phase_reset_R8: assert property (@(posedge clk_i)
    disable iff (!core_rst_i)
    core_rst_i |=> (phase_q == '0))
    else $error("R8 phase not cleared");

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl #(
  parameter int unsigned OSC_PER_MC  = 12,
  parameter int unsigned QUAL_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_pin_i,
  input  logic mode_wr_i,
  input  logic set_idle_i,
  input  logic set_pdown_i,
  input  logic wake_irq_i,
  output logic cpu_clk_en_o,
  output logic periph_clk_en_o,
  output logic core_rst_o,
  output logic mcyc_tick_o,
  output logic idle_o,
  output logic pdown_o
);
  import pmc_pkg::*;

  pm_state_e mode_state;
  logic      periph_en;

  pmc_rst_qual #(
    .OSC_PER_MC (OSC_PER_MC),
    .QUAL_MC    (QUAL_MC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rst_qual (
    .clk_i     (clk_i),
    .rst_pin_i (rst_pin_i),
    .core_rst_o(core_rst_o)
  );

  pmc_mode_fsm u_mode_fsm (
    .clk_i      (clk_i),
    .core_rst_i (core_rst_o),
    .mode_wr_i  (mode_wr_i),
    .set_idle_i (set_idle_i),
    .set_pdown_i(set_pdown_i),
    .wake_irq_i (wake_irq_i),
    .state_o    (mode_state)
  );

  assign periph_en       = (mode_state != PM_HALT);
  assign cpu_clk_en_o    = (mode_state == PM_RUN);
  assign periph_clk_en_o = periph_en;
  assign idle_o          = (mode_state == PM_IDLE);
  assign pdown_o         = (mode_state == PM_HALT);

  pmc_mcyc_timer #(
    .OSC_PER_MC(OSC_PER_MC)
  ) u_mcyc_timer (
    .clk_i     (clk_i),
    .core_rst_i(core_rst_o),
    .run_en_i  (periph_en),
    .tick_o    (mcyc_tick_o)
  );

  assert_idle_enables_R1: assert property (@(posedge clk_i)
    disable iff (core_rst_o)
    idle_o |-> (periph_clk_en_o && !cpu_clk_en_o))
    else $error("R1 idle enables wrong");

  assert_halt_enables_R2: assert property (@(posedge clk_i)
    disable iff (core_rst_o)
    pdown_o |-> (!cpu_clk_en_o && !periph_clk_en_o && !mcyc_tick_o))
    else $error("R2 halt enables wrong");

  assert_halt_sticky_R3: assert property (@(posedge clk_i)
    disable iff (core_rst_o)
    pdown_o |=> pdown_o)
    else $error("R3 halt left without reset");

  assert_modes_exclusive_R10: assert property (@(posedge clk_i)
    disable iff (core_rst_o)
    $onehot0({idle_o, pdown_o}))
    else $error("R10 both mode bits set");

endmodule

// File: tb/pmc_power_ctrl_bench.sv
`timescale 1ns/1ps
module pmc_power_ctrl_bench;
  logic clk = 1'b0;
  logic rst_pin = 1'b0, wr = 1'b0, b_idle = 1'b0, b_pd = 1'b0, irq = 1'b0;
  logic cpu_en, per_en, crst, tick, idle, pd;

  int checks = 0, fails = 0;
  bit started = 1'b0, done = 1'b0;

  // behavioural reference state
  int m_s1 = 0, m_s2 = 0, m_cnt = 0, m_mode = 0, m_phase = 0;
  int n_s1, n_s2, n_cnt, n_mode, n_phase;

  always #2.5 clk = ~clk;

  pmc_power_ctrl u_pmc_power_ctrl (
    .clk_i(clk), .rst_pin_i(rst_pin), .mode_wr_i(wr), .set_idle_i(b_idle),
    .set_pdown_i(b_pd), .wake_irq_i(irq), .cpu_clk_en_o(cpu_en),
    .periph_clk_en_o(per_en), .core_rst_o(crst), .mcyc_tick_o(tick),
    .idle_o(idle), .pdown_o(pd));

  always @(posedge clk) begin
    n_s1 = rst_pin ? 1 : 0;
    n_s2 = m_s1;
    n_cnt = (m_s2 == 0) ? 0 : ((m_cnt >= 24) ? 24 : m_cnt + 1);
    if (m_cnt == 24) begin
      n_mode = 0; n_phase = 0;
    end else begin
      n_mode = m_mode;
      if (m_mode == 0) begin
        if (wr && b_pd) n_mode = 2;
        else if (wr && b_idle) n_mode = 1;
      end else if (m_mode == 1 && irq) n_mode = 0;
      n_phase = (m_mode != 2) ? (m_phase + 1) % 12 : m_phase;
    end
    m_s1 = n_s1; m_s2 = n_s2; m_cnt = n_cnt; m_mode = n_mode; m_phase = n_phase;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(cpu_en, m_mode == 0, "R1/R2 cpu_clk_en model");
    chk(per_en, m_mode != 2, "R1/R2 periph_clk_en model");
    chk(crst, m_cnt == 24, "R4/R5 core_rst model");
    chk(tick, (m_mode != 2) && (m_phase == 11), "R9 tick model");
    chk(idle, m_mode == 1, "R6/R10 idle model");
    chk(pd, m_mode == 2, "R3/R7 pdown model");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mwrite(input logic i, input logic p);
    @(negedge clk); wr = 1'b1; b_idle = i; b_pd = p;
    @(negedge clk); wr = 1'b0; b_idle = 1'b0; b_pd = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
  endtask

  task automatic hw_reset(input int len);
    @(negedge clk); rst_pin = 1'b1;
    cyc(len);
    rst_pin = 1'b0;
    cyc(4);
  endtask

  initial begin
    int ticks;
    started = 1'b1;
    hw_reset(30);
    chk(crst, 1'b0, "R8 reset released");
    chk(cpu_en, 1'b1, "R8 run after reset");
    chk(idle | pd, 1'b0, "R8 mode bits cleared");

    ticks = 0;
    for (int k = 0; k < 48; k++) begin @(negedge clk); if (tick) ticks++; end
    chk(ticks == 4, 1'b1, "R9 four ticks in 48 clocks");

    mwrite(1'b0, 1'b0);
    chk(cpu_en, 1'b1, "R10 empty write ignored");
    pulse_irq();
    chk(cpu_en, 1'b1, "R6 irq in run no effect");

    mwrite(1'b1, 1'b0);
    chk(cpu_en, 1'b0, "R1 cpu gated in idle");
    chk(per_en, 1'b1, "R1 periph on in idle");
    ticks = 0;
    for (int k = 0; k < 24; k++) begin @(negedge clk); if (tick) ticks++; end
    chk(ticks == 2, 1'b1, "R9 ticks continue in idle");
    mwrite(1'b0, 1'b1);
    chk(pd, 1'b0, "R10 write in idle ignored");
    pulse_irq();
    chk(cpu_en, 1'b1, "R6 wake from idle");

    mwrite(1'b1, 1'b1);
    chk(pd, 1'b1, "R7 power-down wins");
    chk(per_en, 1'b0, "R2 periph gated in halt");
    pulse_irq();
    mwrite(1'b1, 1'b0);
    cyc(30);
    chk(pd, 1'b1, "R3 halt ignores irq and writes");
    chk(tick, 1'b0, "R2 no tick in halt");

    @(negedge clk); rst_pin = 1'b1;
    cyc(25);
    chk(crst, 1'b0, "R4 not yet at 25 edges");
    cyc(1);
    chk(crst, 1'b1, "R4 asserted at 26th edge");
    cyc(5);
    chk(crst, 1'b1, "R4 held while pin high");
    rst_pin = 1'b0;
    cyc(2);
    chk(crst, 1'b1, "R5 still high two edges after release");
    cyc(1);
    chk(crst, 1'b0, "R5 released on third edge");
    chk(pd, 1'b0, "R3 halt left by reset");

    mwrite(1'b0, 1'b1);
    chk(pd, 1'b1, "R7 power-down only");
    hw_reset(20);
    chk(pd, 1'b1, "R5 short pulse rejected");
    @(negedge clk); rst_pin = 1'b1;
    cyc(20); rst_pin = 1'b0; cyc(1); rst_pin = 1'b1; cyc(20); rst_pin = 1'b0;
    cyc(4);
    chk(pd, 1'b1, "R5 split pulse rejected");
    hw_reset(40);
    chk(pd, 1'b0, "R8 reset clears halt");
    mwrite(1'b1, 1'b0);
    hw_reset(30);
    chk(idle, 1'b0, "R8 reset clears idle");
    cyc(30);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 timeout actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule